// File: doc/BRIEF.md
# SPI Master Clock-Stop Transfer Engine

This block is the master side of a buffered serial port used in clock-stop mode. A host programs an integer divider, a word length and a parallel transmit word, then pulses a start strobe. The engine derives the serial clock from the core clock, holds an active-low slave select low around the whole word, shifts the transmit word out most significant bit first and shifts the received bits in. It returns the received word together with a one-cycle done pulse.

The serial clock rests low between words. Outgoing data changes only when the serial clock falls, and incoming data is captured in the same core cycle that the serial clock rises. When the divider is even, the serial clock has an uneven duty cycle and the high phase is the longer one. Slave select leads the first rising edge by one high-phase width and lags the final falling edge by one low-phase width. The data driver is released at the final falling edge, and a separate enable output marks when the line is driven.

Top module: `spi_cs_master`

## Requirements
- R1: The serial clock period is (D + 1) core cycles, where D is the divider input. A divider of 0 is handled as 1, which gives a period of 2 cycles.
- R2: For odd D, the serial clock is high for (D+1)/2 cycles and low for (D+1)/2 cycles. For even D, it is high for D/2 + 1 cycles and low for D/2 cycles.
- R3: Out of reset and between transfers, the serial clock is 0, slave select is 1, the data enable is 0 and done is 0.
- R4: Slave select goes low, and the data output presents transmit bit n-1, a full high-phase width before the first rising edge of the serial clock.
- R5: After the final falling edge, slave select stays low for one low-phase width and then returns to 1. The serial clock stays low during this time.
- R6: Exactly n rising edges occur in each transfer. The data output sends bits n-1 down to 0, changes only in the cycle the clock falls, and is stable while the clock is high.
- R7: The data input is captured in the core cycle in which the serial clock rises. The received word places the first received bit at position n-1, and the bits above n-1 are zero.
- R8: The data enable is 1 from the fall of slave select until the final falling edge of the serial clock, and is 0 from that edge onward. When it is 0, the data output is high impedance.
- R9: Done is high for exactly one core cycle, the cycle in which slave select returns high. The received word is valid in that cycle and stays unchanged until the next done.
- R10: A start strobe that arrives while a transfer is in progress has no effect on that transfer and does not start another one.
- R11: The word length input n is clamped to the range 8 to 32. A value below 8 gives 8, and a value above 32 gives 32.
- R12: When start is sampled high in idle, slave select is low in the very next core cycle. The divider, the length and the transmit word are latched at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_i | input | DIV_W (8) | Clock divider value D |
| word_len_i | input | LEN_W (6) | Requested word length n in bits |
| tx_word_i | input | MAX_LEN (32) | Transmit word, right-aligned |
| start_i | input | 1 | Start strobe, one core cycle |
| rx_word_o | output | MAX_LEN (32) | Received word, right-aligned |
| done_o | output | 1 | One-cycle transfer-complete pulse |
| sclk_o | output | 1 | Serial clock, rests low |
| ss_n_o | output | 1 | Active-low slave select |
| sdo_o | output | 1 | Serial data out, high impedance when not driven |
| sdo_oe_o | output | 1 | Data output enable |
| sdi_i | input | 1 | Serial data in |

## Verification
The assertions assume two things about the inputs. First, start is a pulse from the host, and it may also arrive during a transfer. Second, the data input from the slave only changes while the serial clock is low, so the value captured at a rising edge is settled. The bench's slave model changes the data input only when slave select falls and at falling clock edges. The divider, the length and the transmit word may change during a transfer, and one directed test changes all of them mid-word to show that the engine ignores them.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_LAG
    } spi_st_e;

endpackage

// File: rtl/spi_cs_phase_calc.sv
// Derives the high and low phase widths of the serial clock from the divider
// value, and clamps the requested word length to the supported range.
module spi_cs_phase_calc #(
    parameter int DIV_W   = 8,
    parameter int MIN_LEN = 8,
    parameter int MAX_LEN = 32,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int CNT_W  = DIV_W + 1
) (
    input  logic [DIV_W-1:0] div_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [CNT_W-1:0] hi_w_o,
    output logic [CNT_W-1:0] lo_w_o,
    output logic [LEN_W-1:0] len_o
);

    logic [CNT_W-1:0] d_eff;

    always_comb begin
        // A divider of 0 runs as 1, so every phase lasts at least one core cycle.
        d_eff  = (div_i == '0) ? CNT_W'(1) : {1'b0, div_i};
        // The high phase gets the extra cycle when the period is odd.
        hi_w_o = (d_eff + CNT_W'(2)) >> 1;
        lo_w_o = d_eff + CNT_W'(1) - hi_w_o;
        if (len_i < LEN_W'(MIN_LEN))
            len_o = LEN_W'(MIN_LEN);
        else if (len_i > LEN_W'(MAX_LEN))
            len_o = LEN_W'(MAX_LEN);
        else
            len_o = len_i;
    end

    // R2: the phases differ by at most one cycle and the high phase is never the shorter one
    always_comb begin
        a_r2_phase_split: assert (hi_w_o >= lo_w_o && (hi_w_o - lo_w_o) <= CNT_W'(1) && lo_w_o != '0);
    end

endmodule

// File: rtl/spi_cs_shifter.sv
// Transmit and receive shift registers. The transmit word is left-aligned
// when loaded, so the outgoing bit is always taken from the top position.
module spi_cs_shifter #(
    parameter int MAX_LEN = 32,
    localparam int LEN_W  = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic [MAX_LEN-1:0] word_i,
    input  logic [LEN_W-1:0]   len_i,
    input  logic               shift_i,
    input  logic               cap_i,
    input  logic               sdi_i,
    output logic               sdo_o,
    output logic [MAX_LEN-1:0] rx_o
);

    localparam logic [LEN_W-1:0] MAXL = LEN_W'(MAX_LEN);

    typedef struct packed {
        logic [MAX_LEN-1:0] tx;
        logic [MAX_LEN-1:0] rx;
    } sh_t;

    sh_t sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d.tx = word_i << (MAXL - len_i);
            sh_d.rx = '0;
        end else begin
            if (shift_i)
                sh_d.tx = {sh_q.tx[MAX_LEN-2:0], 1'b0};
            if (cap_i)
                sh_d.rx = {sh_q.rx[MAX_LEN-2:0], sdi_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            sh_q <= '0;
        else
            sh_q <= sh_d;
    end

    assign sdo_o = sh_q.tx[MAX_LEN-1];
    assign rx_o  = sh_q.rx;

    // R7: a new word starts with an empty receive register
    a_r7_rx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (rx_o == '0));

endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
    import spi_cs_pkg::*;
#(
    parameter int DIV_W   = 8,
    parameter int MIN_LEN = 8,
    parameter int MAX_LEN = 32,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int CNT_W  = DIV_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DIV_W-1:0]   div_i,
    input  logic [LEN_W-1:0]   word_len_i,
    input  logic [MAX_LEN-1:0] tx_word_i,
    input  logic               start_i,
    output logic [MAX_LEN-1:0] rx_word_o,
    output logic               done_o,
    output logic               sclk_o,
    output logic               ss_n_o,
    output logic               sdo_o,
    output logic               sdo_oe_o,
    input  logic               sdi_i
);

    typedef struct packed {
        spi_st_e            st;
        logic [CNT_W-1:0]   cnt;
        logic [CNT_W-1:0]   hi;
        logic [CNT_W-1:0]   lo;
        logic [LEN_W-1:0]   bits;
        logic               sclk;
        logic               ss_n;
        logic               oe;
        logic               done;
        logic [MAX_LEN-1:0] rxw;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st: ST_IDLE, cnt: '0, hi: '0, lo: '0, bits: '0,
        sclk: 1'b0, ss_n: 1'b1, oe: 1'b0, done: 1'b0, rxw: '0
    };

    ctl_t r_d, r_q;

    logic [CNT_W-1:0]   hi_w, lo_w;
    logic [LEN_W-1:0]   len_c;
    logic               load, shift, cap;
    logic               sdo_bit;
    logic [MAX_LEN-1:0] rx_sh;

    spi_cs_phase_calc #(
        .DIV_W   (DIV_W),
        .MIN_LEN (MIN_LEN),
        .MAX_LEN (MAX_LEN)
    ) u_phase (
        .div_i  (div_i),
        .len_i  (word_len_i),
        .hi_w_o (hi_w),
        .lo_w_o (lo_w),
        .len_o  (len_c)
    );

    spi_cs_shifter #(
        .MAX_LEN (MAX_LEN)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .word_i  (tx_word_i),
        .len_i   (len_c),
        .shift_i (shift),
        .cap_i   (cap),
        .sdi_i   (sdi_i),
        .sdo_o   (sdo_bit),
        .rx_o    (rx_sh)
    );

    always_comb begin
        r_d    = r_q;
        r_d.done = 1'b0;
        load   = 1'b0;
        shift  = 1'b0;
        cap    = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.st   = ST_LEAD;
                    r_d.ss_n = 1'b0;
                    r_d.oe   = 1'b1;
                    r_d.hi   = hi_w;
                    r_d.lo   = lo_w;
                    r_d.cnt  = hi_w - CNT_W'(1);
                    r_d.bits = len_c;
                    load     = 1'b1;
                end
            end
            ST_LEAD, ST_LOW: begin
                if (r_q.cnt == '0) begin
                    // rising edge: capture the input and start the high phase
                    r_d.st   = ST_HIGH;
                    r_d.sclk = 1'b1;
                    r_d.cnt  = r_q.hi - CNT_W'(1);
                    r_d.bits = r_q.bits - LEN_W'(1);
                    cap      = 1'b1;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_HIGH: begin
                if (r_q.cnt == '0) begin
                    // falling edge: present the next bit, or release the line
                    r_d.sclk = 1'b0;
                    r_d.cnt  = r_q.lo - CNT_W'(1);
                    if (r_q.bits == '0) begin
                        r_d.st = ST_LAG;
                        r_d.oe = 1'b0;
                    end else begin
                        r_d.st = ST_LOW;
                        shift  = 1'b1;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_LAG: begin
                if (r_q.cnt == '0) begin
                    r_d.st   = ST_IDLE;
                    r_d.ss_n = 1'b1;
                    r_d.done = 1'b1;
                    r_d.rxw  = rx_sh;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            default: r_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            r_q <= CTL_RST;
        else
            r_q <= r_d;
    end

    assign rx_word_o = r_q.rxw;
    assign done_o    = r_q.done;
    assign sclk_o    = r_q.sclk;
    assign ss_n_o    = r_q.ss_n;
    assign sdo_oe_o  = r_q.oe;
    assign sdo_o     = r_q.oe ? sdo_bit : 1'bz;

    // R3: the clock rests low whenever the slave is not selected
    a_r3_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ss_n |-> !r_q.sclk);

    // R8: the data line is never driven without slave select
    a_r8_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.ss_n |-> !r_q.oe);

    // R1: the serial clock holds its level while a phase counter runs
    a_r1_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st != ST_IDLE && r_q.cnt != '0) |=> $stable(r_q.sclk));

    // R6: outgoing data is stable across the high phase
    a_r6_sdo_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.sclk && $past(r_q.sclk)) |-> $stable(sdo_bit));

    // R9: select returns high only together with the done pulse
    a_r9_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.ss_n) |-> r_q.done);

    // R9: done never lasts two cycles
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.done |=> !r_q.done);

    // R10: a start during a bit phase does not restart the word
    a_r10_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_HIGH && start_i) |=> (r_q.st != ST_LEAD));

endmodule

// File: tb/tb_spi_cs_master.sv
module tb_spi_cs_master;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [7:0]  div;
        logic [5:0]  len;
        logic [31:0] tx;
        logic [31:0] sw;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{8'd1, 6'd8,  32'h000000A5, 32'h0000003C},
        '{8'd2, 6'd8,  32'h00000081, 32'h0000007E},
        '{8'd3, 6'd16, 32'h0000BEEF, 32'h00001234},
        '{8'd4, 6'd12, 32'h00000ABC, 32'h000005A3},
        '{8'd0, 6'd8,  32'h0000005A, 32'h000000C3},
        '{8'd7, 6'd32, 32'hDEADBEEF, 32'h0F1E2D3C},
        '{8'd6, 6'd40, 32'h80000001, 32'hFFFF0000},
        '{8'd5, 6'd3,  32'h000001F0, 32'h00000096}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  div_i = '0;
    logic [5:0]  word_len_i = 6'd8;
    logic [31:0] tx_word_i = '0;
    logic        start_i = 1'b0;
    logic [31:0] rx_word_o;
    logic        done_o, sclk_o, ss_n_o, sdo_o, sdo_oe_o;
    logic        sdi_i = 1'b0;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cs_master dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_i      (div_i),
        .word_len_i (word_len_i),
        .tx_word_i  (tx_word_i),
        .start_i    (start_i),
        .rx_word_o  (rx_word_o),
        .done_o     (done_o),
        .sclk_o     (sclk_o),
        .ss_n_o     (ss_n_o),
        .sdo_o      (sdo_o),
        .sdo_oe_o   (sdo_oe_o),
        .sdi_i      (sdi_i)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int clamp_len(input int n);
        return (n < 8) ? 8 : ((n > 32) ? 32 : n);
    endfunction

    function automatic logic [31:0] mask_of(input int n);
        return (n >= 32) ? 32'hFFFFFFFF : ((32'h1 << n) - 32'h1);
    endfunction

    // expected transfer shape, set by the driving task before each start
    int exp_hi = 1, exp_lo = 1, exp_len = 8;
    logic [31:0] slv_word = '0;

    // monitor state: the monitor samples every core cycle on the falling core edge
    logic prev_ss = 1'b1, prev_sclk = 1'b0, end_pend = 1'b0;
    int   hi_run, lo_run, rises, gap, xfers = 0, extra_done = 0, bad_idle = 0;
    int   bad_lead, bad_hi, bad_lo, bad_per, bad_lag, bad_oe, bad_done;
    logic [31:0] slv_cap, rx_at_done;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_ss && !ss_n_o) begin
                hi_run = 0; lo_run = 1; rises = 0; gap = 0;
                bad_lead = 0; bad_hi = 0; bad_lo = 0; bad_per = 0;
                bad_lag = 0; bad_oe = 0; bad_done = 0; slv_cap = '0;
                sdi_i = slv_word[exp_len-1];
                if (!sdo_oe_o || sclk_o) bad_oe++;
            end else if (!ss_n_o) begin
                if (sclk_o && !prev_sclk) begin
                    if (rises == 0) begin
                        if (lo_run != exp_hi) bad_lead++;
                    end else begin
                        if (lo_run != exp_lo) bad_lo++;
                        if (gap != exp_hi + exp_lo) bad_per++;
                    end
                    slv_cap = {slv_cap[30:0], sdo_o};
                    rises++; hi_run = 1; lo_run = 0; gap = 1;
                    if (!sdo_oe_o) bad_oe++;
                end else if (!sclk_o && prev_sclk) begin
                    if (hi_run != exp_hi) bad_hi++;
                    hi_run = 0; lo_run = 1; gap++;
                    if (rises < exp_len) begin
                        sdi_i = slv_word[exp_len-1-rises];
                        if (!sdo_oe_o) bad_oe++;
                    end else if (sdo_oe_o) bad_oe++;
                end else begin
                    if (sclk_o) hi_run++; else lo_run++;
                    gap++;
                    if ((rises == exp_len && !sclk_o) ? sdo_oe_o : !sdo_oe_o) bad_oe++;
                end
            end else if (!prev_ss && ss_n_o) begin
                if (lo_run != exp_lo || prev_sclk || sclk_o) bad_lag++;
                if (!done_o) bad_done++;
                rx_at_done = rx_word_o;
                end_pend = 1'b1;
                xfers++;
            end else begin
                if (sclk_o || sdo_oe_o) bad_idle++;
                if (done_o) begin
                    extra_done++;
                    if (end_pend) bad_done++;
                end
                end_pend = 1'b0;
            end
            prev_ss = ss_n_o;
            prev_sclk = sclk_o;
        end
    end

    // One word from the table or a directed case. poke_at > 0 issues a second
    // start, with different inputs, that many cycles into the transfer.
    task automatic run_xfer(input logic [7:0] dv, input logic [5:0] ln,
                            input logic [31:0] tx, input logic [31:0] sw,
                            input int poke_at, input string tag);
        int el, de, n, x0;
        el = clamp_len(int'(ln));
        de = (dv == 0) ? 1 : int'(dv);
        exp_hi = (de + 2) / 2;
        exp_lo = de + 1 - exp_hi;
        exp_len = el;
        slv_word = sw;
        x0 = xfers;
        @(negedge clk);
        div_i = dv; word_len_i = ln; tx_word_i = tx; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(ss_n_o == 1'b0, "R12", {tag, " select low one cycle after start"}, 32'(ss_n_o), 32'd0);
        chk(sdo_oe_o && sdo_o == tx[el-1], "R4", {tag, " msb presented in lead"}, 32'(sdo_o), 32'(tx[el-1]));
        n = 0;
        while (xfers == x0 && n < 5000) begin
            @(negedge clk);
            n++;
            if (poke_at > 0 && n == poke_at) begin
                start_i = 1'b1; tx_word_i = 32'hFFFFFFFF; div_i = 8'd1; word_len_i = 6'd8;
            end else begin
                start_i = 1'b0;
            end
        end
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        chk(n < 5000, "R9", {tag, " transfer completes"}, 32'(n), 32'd0);
        chk(bad_lead == 0, "R4", {tag, " lead width"}, 32'(bad_lead), 32'd0);
        chk(bad_hi == 0, "R2", {tag, " high phase width"}, 32'(bad_hi), 32'd0);
        chk(bad_lo == 0, "R2", {tag, " low phase width"}, 32'(bad_lo), 32'd0);
        chk(bad_per == 0, "R1", {tag, " clock period"}, 32'(bad_per), 32'd0);
        chk(bad_lag == 0, "R5", {tag, " lag width"}, 32'(bad_lag), 32'd0);
        chk(rises == el, "R6", {tag, " rising edge count"}, 32'(rises), 32'(el));
        chk((slv_cap & mask_of(el)) == (tx & mask_of(el)), "R6", {tag, " msb-first bits seen by slave"},
            slv_cap & mask_of(el), tx & mask_of(el));
        chk(rx_at_done == (sw & mask_of(el)), "R7", {tag, " received word"}, rx_at_done, sw & mask_of(el));
        chk(bad_oe == 0, "R8", {tag, " data enable window"}, 32'(bad_oe), 32'd0);
        chk(bad_done == 0, "R9", {tag, " single done pulse with select release"}, 32'(bad_done), 32'd0);
        if (ln < 6'd8 || ln > 6'd32)
            chk(rises == el, "R11", {tag, " length clamped"}, 32'(rises), 32'(el));
    endtask

    initial begin
        logic [31:0] held;
        int idle_hits;
        repeat (3) @(negedge clk);
        // R3: reset state
        chk(sclk_o == 1'b0 && ss_n_o == 1'b1 && sdo_oe_o == 1'b0 && done_o == 1'b0,
            "R3", "reset state", {28'd0, sclk_o, ss_n_o, sdo_oe_o, done_o}, 32'h4);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(rx_word_o == '0 && ss_n_o, "R3", "idle after reset", rx_word_o, 32'd0);

        for (int i = 0; i < NVEC; i++)
            run_xfer(VECS[i].div, VECS[i].len, VECS[i].tx, VECS[i].sw, 0, $sformatf("vec%0d", i));

        // R10: a start in mid-transfer, with new divider, length and data, is ignored
        run_xfer(8'd3, 6'd16, 32'h0000C001, 32'h0000A55A, 20, "busy-start");
        idle_hits = 0;
        repeat (30) begin
            @(negedge clk);
            if (!ss_n_o) idle_hits++;
        end
        chk(idle_hits == 0, "R10", "no second word after ignored start", 32'(idle_hits), 32'd0);

        // R9: received word held until the next done
        held = rx_word_o;
        tx_word_i = 32'h12345678; div_i = 8'd9;
        repeat (10) @(negedge clk);
        chk(rx_word_o == held, "R9", "received word held in idle", rx_word_o, held);

        // R1 and R2: the widest even divider case in the run
        run_xfer(8'd10, 6'd9, 32'h00000155, 32'h000000AA, 0, "div10");

        chk(bad_idle == 0, "R3", "clock and enable low between transfers", 32'(bad_idle), 32'd0);
        chk(extra_done == 0, "R9", "no done outside select release", 32'(extra_done), 32'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d cycles", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule